// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits beside the instruction engine of an 8-bit processor core and runs the interrupt side of it. At each instruction boundary the core raises a strobe. The sequencer then decides whether to take a pending non-maskable request or the maskable level request, or neither. A taken request runs the acknowledge cycles. The block saves the return address through two stack pushes, high byte first. In the vectored mode it also fetches the new program counter from a table in memory. When the sequence ends, the block hands the new program counter and the T-state cost of the sequence back to the core.

The block owns the interrupt-enable pair (the live enable and its shadow copy), the 2-bit interrupt mode, the vector page register and the refresh counter. The core changes these through simple write strobes when it executes its enable, disable and load instructions. The core stays stalled while `busy_o` is high. Stack pushes and table reads use a request/acknowledge handshake towards memory. The acknowledging device drives its byte onto `bus_byte_i` during the cycle in which `inta_o` is high.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset the enable pair, the shadow enable, the mode, the vector page and the refresh counter read 0, and `busy_o`, `done_o` and `err_o` are low.
- R2: When a non-maskable request and an enabled maskable request are both present at a boundary, the non-maskable request is taken and the maskable one is left waiting.
- R3: A rising edge on `nmi_i` is remembered until a boundary takes it, and it is taken exactly once. A line held high does not cause a second entry.
- R4: A non-maskable entry clears the live enable and keeps the shadow enable. It pushes the return address high byte first, then low byte, and ends with a new program counter of 0x0066 and a cost of 11 T-states (5+3+3).
- R5: A maskable request is taken only if `int_i` is high in the boundary cycle and the live enable is set. A request that drops before the boundary is lost.
- R6: A maskable entry clears both enables. It adds one to bits 6:0 of the refresh counter and leaves bit 7 unchanged, so 0xFF becomes 0x80.
- R7: If `halt_i` flags that the instruction at the program counter is a halt, the pushed return address is the program counter plus one.
- R8: Mode 1 ends at 0x0038 with a cost of 13 T-states (7+3+3).
- R9: Mode 2 reads two bytes after the pushes. The low byte comes from address {vector page, bus byte} and the high byte from that address plus one, with a carry into the upper byte. The sequence costs 19 T-states.
- R10: In mode 0, a bus byte of the form 11xxx111 (restart) ends at the address byte & 0x38 with a cost of 13 T-states. The byte 0xCD (call) ends at 0xFFFF, because the idle bus reads its operand as all ones, with a cost of 19 T-states.
- R11: Any other mode 0 bus byte, or a mode value of 3, raises `err_o` for one cycle with no push and no `done_o`, and the block returns to idle.
- R12: Reset drops a non-maskable edge that was seen but not yet taken.
- R13: `ei_i` sets both enables and `di_i` clears both. `im_we_i`, `ireg_we_i` and `rreg_we_i` load the mode, the vector page and the refresh counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| pc_i | input | AW | Current program counter |
| halt_i | input | 1 | Instruction at pc_i is a halt |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| int_i | input | 1 | Maskable request, level sensitive |
| bus_byte_i | input | DW | Byte from acknowledging device |
| ei_i | input | 1 | Set both enables |
| di_i | input | 1 | Clear both enables |
| im_we_i | input | 1 | Load interrupt mode |
| im_i | input | 2 | Mode value |
| ireg_we_i | input | 1 | Load vector page |
| ireg_i | input | DW | Vector page value |
| rreg_we_i | input | 1 | Load refresh counter |
| rreg_i | input | DW | Refresh counter value |
| push_ack_i | input | 1 | Stack push accepted |
| rd_ack_i | input | 1 | Table read complete |
| rd_data_i | input | DW | Table read data |
| busy_o | output | 1 | Sequence in progress |
| inta_o | output | 1 | Acknowledge cycle, bus byte sampled |
| push_req_o | output | 1 | Stack push request |
| push_data_o | output | DW | Byte to push |
| rd_req_o | output | 1 | Table read request |
| rd_addr_o | output | AW | Table read address |
| done_o | output | 1 | Sequence complete, new_pc_o valid |
| new_pc_o | output | AW | Entry address |
| tstates_o | output | TSW | T-state cost of the sequence |
| err_o | output | 1 | Unsupported bus opcode or mode |
| iff1_o | output | 1 | Live interrupt enable |
| iff2_o | output | 1 | Shadow interrupt enable |
| im_o | output | 2 | Interrupt mode |
| ireg_o | output | DW | Vector page register |
| rreg_o | output | DW | Refresh counter |

## Verification
The bench uses the default parameters: 8-bit data, a 16-bit address, and 0x0066 and 0x0038 as the fixed entry points. At that width the vector page byte 0x3F and bus byte 0xFF make the second table read carry into a new page. A refresh value of 0xFF shows that bit 7 is kept when bits 6:0 wrap. The memory model returns bytes computed from the address. This lets the bench check the fetched entry address and both read addresses without a stored table.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_PUSH_H, S_PUSH_L, S_RD_L, S_RD_H, S_FIN, S_ERR
  } seq_state_e;

  localparam logic [7:0] OP_CALL  = 8'hCD;
  localparam logic [7:0] RST_MASK = 8'hC7;
  localparam logic [7:0] RST_TGT  = 8'h38;

  localparam int TS_NMI  = 11;
  localparam int TS_IM1  = 13;
  localparam int TS_RST  = 13;
  localparam int TS_CALL = 19;
  localparam int TS_IM2  = 19;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q, pend_q, rise;

  assign rise   = nmi_i & ~nmi_q;
  assign pend_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= take_i ? 1'b0 : pend_o;
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_nmi_i,
  input  logic          take_int_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          im_we_i,
  input  logic [1:0]    im_i,
  input  logic          ireg_we_i,
  input  logic [DW-1:0] ireg_i,
  input  logic          rreg_we_i,
  input  logic [DW-1:0] rreg_i,
  output logic          iff1_o,
  output logic          iff2_o,
  output logic [1:0]    im_o,
  output logic [DW-1:0] ireg_o,
  output logic [DW-1:0] rreg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
      im_o   <= 2'd0;
      ireg_o <= '0;
      rreg_o <= '0;
    end else begin
      if (take_int_i) begin
        iff1_o <= 1'b0;
        iff2_o <= 1'b0;
      end else if (take_nmi_i) begin
        iff1_o <= 1'b0;
      end else if (di_i) begin
        iff1_o <= 1'b0;
        iff2_o <= 1'b0;
      end else if (ei_i) begin
        iff1_o <= 1'b1;
        iff2_o <= 1'b1;
      end
      if (im_we_i)   im_o   <= im_i;
      if (ireg_we_i) ireg_o <= ireg_i;
      // refresh bump wraps in the low bits only
      if (take_int_i)     rreg_o <= {rreg_o[DW-1], rreg_o[DW-2:0] + (DW-1)'(1)};
      else if (rreg_we_i) rreg_o <= rreg_i;
    end
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
#(
  parameter int               DW      = 8,
  parameter int               AW      = 16,
  parameter int               TSW     = 6,
  parameter logic [AW-1:0]    NMI_VEC = 16'h0066,
  parameter logic [AW-1:0]    IM1_VEC = 16'h0038
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           boundary_i,
  input  logic [AW-1:0]  pc_i,
  input  logic           halt_i,
  input  logic           nmi_pend_i,
  input  logic           int_i,
  input  logic           iff1_i,
  input  logic [1:0]     im_i,
  input  logic [DW-1:0]  ireg_i,
  input  logic [DW-1:0]  bus_byte_i,
  input  logic           push_ack_i,
  input  logic           rd_ack_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           take_nmi_o,
  output logic           take_int_o,
  output logic           busy_o,
  output logic           inta_o,
  output logic           push_req_o,
  output logic [DW-1:0]  push_data_o,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic           done_o,
  output logic [AW-1:0]  new_pc_o,
  output logic [TSW-1:0] tstates_o,
  output logic           err_o
);
  seq_state_e     state_q;
  logic [AW-1:0]  ret_q, tgt_q, vec_q;
  logic [TSW-1:0] ts_q;
  logic           tbl_q;
  logic           idle;

  assign idle       = (state_q == S_IDLE);
  assign take_nmi_o = idle & boundary_i & nmi_pend_i;
  assign take_int_o = idle & boundary_i & ~nmi_pend_i & int_i & iff1_i;

  assign busy_o      = ~idle;
  assign inta_o      = (state_q == S_ACK);
  assign push_req_o  = (state_q == S_PUSH_H) | (state_q == S_PUSH_L);
  assign push_data_o = (state_q == S_PUSH_H) ? ret_q[AW-1:DW] : ret_q[DW-1:0];
  assign rd_req_o    = (state_q == S_RD_L) | (state_q == S_RD_H);
  assign rd_addr_o   = (state_q == S_RD_H) ? vec_q + AW'(1) : vec_q;
  assign done_o      = (state_q == S_FIN);
  assign err_o       = (state_q == S_ERR);
  assign new_pc_o    = tgt_q;
  assign tstates_o   = ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ret_q   <= '0;
      tgt_q   <= '0;
      vec_q   <= '0;
      ts_q    <= '0;
      tbl_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (take_nmi_o || take_int_o) begin
            ret_q <= pc_i + {{(AW-1){1'b0}}, halt_i};
            tbl_q <= 1'b0;
          end
          if (take_nmi_o) begin
            tgt_q   <= NMI_VEC;
            ts_q    <= TSW'(TS_NMI);
            state_q <= S_PUSH_H;
          end else if (take_int_o) begin
            state_q <= S_ACK;
          end
        end
        S_ACK: begin
          case (im_i)
            2'd0: begin
              if ((bus_byte_i & RST_MASK) == RST_MASK) begin
                tgt_q   <= AW'(bus_byte_i & RST_TGT);
                ts_q    <= TSW'(TS_RST);
                state_q <= S_PUSH_H;
              end else if (bus_byte_i == OP_CALL) begin
                tgt_q   <= '1;
                ts_q    <= TSW'(TS_CALL);
                state_q <= S_PUSH_H;
              end else begin
                state_q <= S_ERR;
              end
            end
            2'd1: begin
              tgt_q   <= IM1_VEC;
              ts_q    <= TSW'(TS_IM1);
              state_q <= S_PUSH_H;
            end
            2'd2: begin
              vec_q   <= {ireg_i, bus_byte_i};
              ts_q    <= TSW'(TS_IM2);
              tbl_q   <= 1'b1;
              state_q <= S_PUSH_H;
            end
            default: state_q <= S_ERR;
          endcase
        end
        S_PUSH_H: if (push_ack_i) state_q <= S_PUSH_L;
        S_PUSH_L: if (push_ack_i) state_q <= tbl_q ? S_RD_L : S_FIN;
        S_RD_L: if (rd_ack_i) begin
          tgt_q[DW-1:0] <= rd_data_i;
          state_q       <= S_RD_H;
        end
        S_RD_H: if (rd_ack_i) begin
          tgt_q[AW-1:DW] <= rd_data_i;
          state_q        <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        S_ERR:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int            DW      = 8,
  parameter int            AW      = 2 * DW,
  parameter int            TSW     = 6,
  parameter logic [AW-1:0] NMI_VEC = 16'h0066,
  parameter logic [AW-1:0] IM1_VEC = 16'h0038
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           boundary_i,
  input  logic [AW-1:0]  pc_i,
  input  logic           halt_i,
  input  logic           nmi_i,
  input  logic           int_i,
  input  logic [DW-1:0]  bus_byte_i,
  input  logic           ei_i,
  input  logic           di_i,
  input  logic           im_we_i,
  input  logic [1:0]     im_i,
  input  logic           ireg_we_i,
  input  logic [DW-1:0]  ireg_i,
  input  logic           rreg_we_i,
  input  logic [DW-1:0]  rreg_i,
  input  logic           push_ack_i,
  input  logic           rd_ack_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic           busy_o,
  output logic           inta_o,
  output logic           push_req_o,
  output logic [DW-1:0]  push_data_o,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic           done_o,
  output logic [AW-1:0]  new_pc_o,
  output logic [TSW-1:0] tstates_o,
  output logic           err_o,
  output logic           iff1_o,
  output logic           iff2_o,
  output logic [1:0]     im_o,
  output logic [DW-1:0]  ireg_o,
  output logic [DW-1:0]  rreg_o
);
  logic nmi_pend, take_nmi, take_int;

  irq_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (take_nmi),
    .pend_o (nmi_pend)
  );

  irq_state_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_nmi_i (take_nmi),
    .take_int_i (take_int),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .im_we_i    (im_we_i),
    .im_i       (im_i),
    .ireg_we_i  (ireg_we_i),
    .ireg_i     (ireg_i),
    .rreg_we_i  (rreg_we_i),
    .rreg_i     (rreg_i),
    .iff1_o     (iff1_o),
    .iff2_o     (iff2_o),
    .im_o       (im_o),
    .ireg_o     (ireg_o),
    .rreg_o     (rreg_o)
  );

  irq_ack_fsm #(
    .DW(DW), .AW(AW), .TSW(TSW), .NMI_VEC(NMI_VEC), .IM1_VEC(IM1_VEC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary_i),
    .pc_i        (pc_i),
    .halt_i      (halt_i),
    .nmi_pend_i  (nmi_pend),
    .int_i       (int_i),
    .iff1_i      (iff1_o),
    .im_i        (im_o),
    .ireg_i      (ireg_o),
    .bus_byte_i  (bus_byte_i),
    .push_ack_i  (push_ack_i),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .take_nmi_o  (take_nmi),
    .take_int_o  (take_int),
    .busy_o      (busy_o),
    .inta_o      (inta_o),
    .push_req_o  (push_req_o),
    .push_data_o (push_data_o),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .done_o      (done_o),
    .new_pc_o    (new_pc_o),
    .tstates_o   (tstates_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
  parameter int DW  = 8,
  parameter int AW  = 16,
  parameter int TSW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           boundary_i,
  input logic [AW-1:0]  pc_i,
  input logic           halt_i,
  input logic           nmi_i,
  input logic           int_i,
  input logic [DW-1:0]  bus_byte_i,
  input logic           ei_i,
  input logic           di_i,
  input logic           im_we_i,
  input logic [1:0]     im_i,
  input logic           ireg_we_i,
  input logic [DW-1:0]  ireg_i,
  input logic           rreg_we_i,
  input logic [DW-1:0]  rreg_i,
  input logic           push_ack_i,
  input logic           rd_ack_i,
  input logic [DW-1:0]  rd_data_i,
  input logic           busy_o,
  input logic           inta_o,
  input logic           push_req_o,
  input logic [DW-1:0]  push_data_o,
  input logic           rd_req_o,
  input logic [AW-1:0]  rd_addr_o,
  input logic           done_o,
  input logic [AW-1:0]  new_pc_o,
  input logic [TSW-1:0] tstates_o,
  input logic           err_o,
  input logic           iff1_o,
  input logic           iff2_o,
  input logic [1:0]     im_o,
  input logic [DW-1:0]  ireg_o,
  input logic [DW-1:0]  rreg_o
);
  p_one_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, push_req_o, rd_req_o, inta_o}));

  p_shadow_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iff2_o) |-> !iff1_o);

  p_bit7_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rreg_we_i |=> rreg_o[DW-1] == $past(rreg_o[DW-1]));

  p_table_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> im_o == 2'd2);

  p_cost_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tstates_o == TSW'(11) || tstates_o == TSW'(13) || tstates_o == TSW'(19)));

  p_back_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !busy_o);

  p_nmi_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tstates_o == TSW'(11)) |-> !iff1_o);
endmodule

bind irq_ack_seq irq_ack_seq_chk #(.DW(DW), .AW(AW), .TSW(TSW)) u_chk (.*);

// File: tb/tb_irq_ack_seq.sv
`timescale 1ns/1ps
module tb_irq_ack_seq;
  localparam int DW = 8, AW = 16, TSW = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic boundary_i = 0, halt_i = 0, nmi_i = 0, int_i = 0;
  logic [AW-1:0] pc_i = '0;
  logic [DW-1:0] bus_byte_i = '0, ireg_i = '0, rreg_i = '0, rd_data_i;
  logic ei_i = 0, di_i = 0, im_we_i = 0, ireg_we_i = 0, rreg_we_i = 0;
  logic [1:0] im_i = '0;
  logic push_ack_i = 1'b1, rd_ack_i = 1'b1;
  logic busy_o, inta_o, push_req_o, rd_req_o, done_o, err_o, iff1_o, iff2_o;
  logic [DW-1:0] push_data_o, ireg_o, rreg_o;
  logic [AW-1:0] rd_addr_o, new_pc_o;
  logic [TSW-1:0] tstates_o;
  logic [1:0] im_o;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rd_data_i = mem_f(rd_addr_o);

  irq_ack_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary_i), .pc_i(pc_i), .halt_i(halt_i),
    .nmi_i(nmi_i), .int_i(int_i), .bus_byte_i(bus_byte_i), .ei_i(ei_i), .di_i(di_i),
    .im_we_i(im_we_i), .im_i(im_i), .ireg_we_i(ireg_we_i), .ireg_i(ireg_i),
    .rreg_we_i(rreg_we_i), .rreg_i(rreg_i), .push_ack_i(push_ack_i), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .inta_o(inta_o), .push_req_o(push_req_o),
    .push_data_o(push_data_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .done_o(done_o),
    .new_pc_o(new_pc_o), .tstates_o(tstates_o), .err_o(err_o), .iff1_o(iff1_o),
    .iff2_o(iff2_o), .im_o(im_o), .ireg_o(ireg_o), .rreg_o(rreg_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // captured sequence
  logic [7:0]  got_push [2];
  logic [15:0] got_rd [2];
  int npush, nrd;
  logic saw_done, saw_err;
  logic [15:0] got_pc;
  int got_ts;

  task automatic pulse_boundary();
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic run_seq();
    npush = 0; nrd = 0; saw_done = 0; saw_err = 0; got_pc = '0; got_ts = 0;
    pulse_boundary();
    for (int i = 0; i < 20; i++) begin
      if (push_req_o && npush < 2) begin got_push[npush] = push_data_o; npush++; end
      if (rd_req_o && nrd < 2) begin got_rd[nrd] = rd_addr_o; nrd++; end
      if (done_o) begin saw_done = 1; got_pc = new_pc_o; got_ts = int'(tstates_o); end
      if (err_o) saw_err = 1;
      if (done_o || err_o) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wr_ei(); ei_i = 1; @(negedge clk); ei_i = 0; endtask
  task automatic wr_di(); di_i = 1; @(negedge clk); di_i = 0; endtask
  task automatic wr_im(input logic [1:0] m); im_i = m; im_we_i = 1; @(negedge clk); im_we_i = 0; endtask
  task automatic wr_i(input logic [7:0] v); ireg_i = v; ireg_we_i = 1; @(negedge clk); ireg_we_i = 0; endtask
  task automatic wr_r(input logic [7:0] v); rreg_i = v; rreg_we_i = 1; @(negedge clk); rreg_we_i = 0; endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!iff1_o && !iff2_o, "R1 enables", {iff1_o, iff2_o}, 0);
    chk(im_o == 0 && ireg_o == 0 && rreg_o == 0, "R1 regs", {im_o, ireg_o, rreg_o}, 0);
    chk(!busy_o && !done_o && !err_o, "R1 idle", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_regs();
    wr_ei();
    chk(iff1_o && iff2_o, "R13 ei", {iff1_o, iff2_o}, 3);
    wr_di();
    chk(!iff1_o && !iff2_o, "R13 di", {iff1_o, iff2_o}, 0);
    wr_im(2); wr_i(8'h5C); wr_r(8'h13);
    chk(im_o == 2 && ireg_o == 8'h5C && rreg_o == 8'h13, "R13 loads",
        {im_o, ireg_o, rreg_o}, {2'd2, 8'h5C, 8'h13});
  endtask

  task automatic t_masked();
    wr_di();
    int_i = 1;
    pulse_boundary();
    chk(!busy_o && !inta_o, "R5 masked", busy_o, 0);
    int_i = 0;
    wr_ei();
    int_i = 1; @(negedge clk); int_i = 0; @(negedge clk);
    pulse_boundary();
    chk(!busy_o && iff1_o, "R5 lost", {busy_o, iff1_o}, 1);
  endtask

  task automatic t_im1();
    wr_ei(); wr_im(1); wr_r(8'hFF);
    pc_i = 16'h1234; halt_i = 1; int_i = 1;
    run_seq();
    int_i = 0; halt_i = 0;
    chk(npush == 2 && got_push[0] == 8'h12 && got_push[1] == 8'h35, "R7 halt pushes",
        {got_push[0], got_push[1]}, 16'h1235);
    chk(saw_done && got_pc == 16'h0038, "R8 vector", got_pc, 16'h0038);
    chk(got_ts == 13, "R8 cost", got_ts, 13);
    chk(!iff1_o && !iff2_o, "R6 enables", {iff1_o, iff2_o}, 0);
    chk(rreg_o == 8'h80, "R6 refresh", rreg_o, 8'h80);
  endtask

  task automatic t_nmi();
    wr_ei(); wr_im(1);
    int_i = 1;
    nmi_i = 1; @(negedge clk); nmi_i = 0; @(negedge clk);
    pc_i = 16'hABCD;
    run_seq();
    chk(npush == 2 && got_push[0] == 8'hAB && got_push[1] == 8'hCD, "R4 push order",
        {got_push[0], got_push[1]}, 16'hABCD);
    chk(saw_done && got_pc == 16'h0066, "R2 nmi first", got_pc, 16'h0066);
    chk(got_ts == 11, "R4 cost", got_ts, 11);
    chk(!iff1_o && iff2_o, "R4 enables", {iff1_o, iff2_o}, 1);
    pulse_boundary();
    chk(!busy_o, "R3 taken once", busy_o, 0);
    int_i = 0;
    nmi_i = 1;
    run_seq();
    chk(saw_done && got_pc == 16'h0066, "R3 edge held", got_pc, 16'h0066);
    pulse_boundary();
    chk(!busy_o, "R3 level no retake", busy_o, 0);
    nmi_i = 0;
    @(negedge clk);
  endtask

  task automatic t_im2();
    wr_ei(); wr_im(2); wr_i(8'h3F);
    bus_byte_i = 8'hFF; pc_i = 16'h0100; int_i = 1;
    run_seq();
    int_i = 0;
    chk(nrd == 2 && got_rd[0] == 16'h3FFF && got_rd[1] == 16'h4000, "R9 table addr",
        {got_rd[0], got_rd[1]}, 32'h3FFF4000);
    chk(got_pc == {mem_f(16'h4000), mem_f(16'h3FFF)}, "R9 entry", got_pc,
        {mem_f(16'h4000), mem_f(16'h3FFF)});
    chk(got_ts == 19, "R9 cost", got_ts, 19);
  endtask

  task automatic t_im0();
    wr_ei(); wr_im(0);
    bus_byte_i = 8'hEF; pc_i = 16'h2000; int_i = 1;
    run_seq();
    chk(saw_done && got_pc == 16'h0028 && got_ts == 13, "R10 restart", got_pc, 16'h0028);
    wr_ei();
    bus_byte_i = 8'hCD;
    run_seq();
    int_i = 0;
    chk(saw_done && got_pc == 16'hFFFF && got_ts == 19, "R10 call", got_pc, 16'hFFFF);
    chk(npush == 2, "R10 call pushes", npush, 2);
  endtask

  task automatic t_err();
    wr_ei(); wr_im(0);
    bus_byte_i = 8'h00; int_i = 1;
    run_seq();
    chk(saw_err && !saw_done && npush == 0, "R11 bad opcode", {saw_err, saw_done, npush}, 4);
    chk(!busy_o, "R11 idle", busy_o, 0);
    wr_ei(); wr_im(3);
    run_seq();
    int_i = 0;
    chk(saw_err && npush == 0, "R11 bad mode", {saw_err, npush}, 2);
  endtask

  task automatic t_reset_nmi();
    nmi_i = 1; @(negedge clk); nmi_i = 0; @(negedge clk);
    do_reset();
    pulse_boundary();
    chk(!busy_o, "R12 pending dropped", busy_o, 0);
    t_reset();
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_regs();
    t_masked();
    t_im1();
    t_nmi();
    t_im2();
    t_im0();
    t_err();
    t_reset_nmi();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule